// File: doc/BRIEF.md
# Single-Slope PWM Timer with Compare Output

This block is an 8-bit up-counting timer that produces a pulse-width-modulated waveform. A clock-enable tick from a selectable divider advances the counter from zero to its top value of 255, after which it returns to zero. This gives a waveform period of 256 ticks. One compare unit holds the duty value. The output takes one level from the start of the period up to and including the tick on which the counter equals the compare value, and the opposite level for the rest of the period.

Software reaches the block through a small write port with three addresses: a compare value, a configuration byte (divider select and a 2-bit output mode), and a flag-clear register. The compare value is double-buffered. A write goes to a holding register, and the value that the comparison uses is reloaded only when the counter wraps, so a period in progress always finishes with the duty it started with. Two sticky flags report the wrap and the compare match. An output-enable input stands in for the pin's direction control.

Top module: `pwm_timer8`

## Requirements
- R1: On each tick the counter advances by one from 0. On the tick taken while it holds 255 it returns to 0, so one period lasts 256 ticks.
- R2: The divider select is bits [2:0] of the configuration byte (address 1). Codes 1, 2, 3, 4 and 5 give one tick every 1, 8, 64, 256 and 1024 clocks. Codes 0, 6 and 7 stop the counter, and the output and flags then hold.
- R3: A configuration write that changes the divider select restarts the divider from zero.
- R4: The overflow flag sets on the tick that takes the counter from 255 to 0. It is visible in the cycle in which the counter reads 0.
- R5: The compare flag sets on every tick taken while the counter equals the active compare value.
- R6: Both flags are sticky. Writing address 2 with bit 0 set clears the overflow flag, and with bit 1 set clears the compare flag. If a set and a clear fall in the same cycle, the flag stays set.
- R7: Output mode is bits [5:4] of the configuration byte. With mode 2 the output is high while the counter is between 0 and the active compare value inclusive, which is value+1 ticks per period. With mode 3 it is the complement.
- R8: A compare value of 0 gives a high spike of one tick per period in mode 2. A value of 255 gives a constant high in mode 2 and a constant low in mode 3.
- R9: A write to address 0 loads only the holding register. The active compare value takes it on the wrap tick, so the period in progress keeps its old duty.
- R10: In modes 0 and 1, or while the output-enable input is low, the PWM output is low.
- R11: After reset the counter and both compare registers are 0, the divider select is 0 (stopped), the mode is 0, both flags are low and the output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 2 | 0 compare holding register, 1 configuration, 2 flag clear |
| wr_data | input | 8 | Write data |
| oe | input | 1 | Output enable for the PWM output |
| pwm_out | output | 1 | PWM waveform |
| ovf_flag | output | 1 | Sticky wrap flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
The bench goes after the two extreme duty values. A design that let the clear-on-match win over the set-at-zero would lose the constant-high output at 255. A design that matched one count late would stretch the zero-value spike to two ticks. It writes a new compare value halfway through a high phase. A design without the holding register would cut that phase short instead of finishing it at the old width. It also clears the flags continuously while they are being set, slows the divider and stops it. This exposes a clear that overrides a set, a wrong divide ratio, and a divider that keeps its old phase after a select change.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic [1:0] {
    OM_IDLE0  = 2'd0,
    OM_IDLE1  = 2'd1,
    OM_NONINV = 2'd2,
    OM_INV    = 2'd3
  } outmode_e;

  typedef enum logic [1:0] {
    ADDR_CMP  = 2'd0,
    ADDR_CFG  = 2'd1,
    ADDR_FLAG = 2'd2,
    ADDR_NONE = 2'd3
  } regaddr_e;

  // log2 of the divide ratio for each select code; -1 means stopped
  function automatic int presc_shift(input logic [2:0] sel);
    case (sel)
      3'd1:    return 0;
      3'd2:    return 3;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 10;
      default: return -1;
    endcase
  endfunction

endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
  import pwm_timer_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       restart,
  output logic       tick
);

  logic [DIV_W-1:0] div_q, div_d, limit;
  logic             run;
  int               sh;

  always_comb begin
    sh    = presc_shift(sel);
    run   = (sh >= 0);
    limit = run ? ((DIV_W'(1) << sh) - DIV_W'(1)) : '0;
    tick  = run && (div_q == limit);
  end

  always_comb begin
    if (restart || !run)   div_d = '0;
    else if (div_q == limit) div_d = '0;
    else                     div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    wrap  = tick && (cnt == TOP);
    cnt_d = tick ? cnt + CNT_W'(1) : cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/ptmr_wavegen.sv
module ptmr_wavegen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] hold_val,
  output logic [CNT_W-1:0] ocr_act,
  output logic             wave,
  output logic             match
);

  logic [CNT_W-1:0] ocr_d;
  logic             wave_d;

  always_comb begin
    match  = tick && (cnt == ocr_act);
    ocr_d  = wrap ? hold_val : ocr_act;
    // set at the start of a period wins over a match on the last count
    if (wrap)       wave_d = 1'b1;
    else if (match) wave_d = 1'b0;
    else            wave_d = wave;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocr_act <= '0;
      wave    <= 1'b1;
    end else begin
      ocr_act <= ocr_d;
      wave    <= wave_d;
    end
  end

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             oe,
  output logic             pwm_out,
  output logic             ovf_flag,
  output logic             cmp_flag
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  logic             wr_cmp, wr_cfg, wr_flg;
  logic             clr_ovf, clr_cmp, restart;
  logic [2:0]       sel_q, sel_d;
  outmode_e         mode_q, mode_d;
  logic [CNT_W-1:0] hold_q, hold_d;
  logic             ovf_d, cmp_d;
  logic             tick, wrap, match, wave, pol;
  logic [CNT_W-1:0] cnt, ocr_act;
  logic             unused_bits;

  always_comb begin
    wr_cmp  = wr_en && (wr_addr == ADDR_CMP);
    wr_cfg  = wr_en && (wr_addr == ADDR_CFG);
    wr_flg  = wr_en && (wr_addr == ADDR_FLAG);
    clr_ovf = wr_flg && wr_data[0];
    clr_cmp = wr_flg && wr_data[1];
    restart = wr_cfg && (wr_data[2:0] != sel_q);
    sel_d   = wr_cfg ? wr_data[2:0] : sel_q;
    mode_d  = wr_cfg ? outmode_e'(wr_data[5:4]) : mode_q;
    hold_d  = wr_cmp ? wr_data : hold_q;
    ovf_d   = wrap  || (ovf_flag && !clr_ovf);
    cmp_d   = match || (cmp_flag && !clr_cmp);
  end

  assign unused_bits = ^{wr_data[CNT_W-1:6], wr_data[3]};

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q    <= '0;
      mode_q   <= OM_IDLE0;
      hold_q   <= '0;
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      sel_q    <= sel_d;
      mode_q   <= mode_d;
      hold_q   <= hold_d;
      ovf_flag <= ovf_d;
      cmp_flag <= cmp_d;
    end
  end

  ptmr_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sel     (sel_q),
    .restart (restart),
    .tick    (tick)
  );

  ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick),
    .cnt   (cnt),
    .wrap  (wrap)
  );

  ptmr_wavegen #(.CNT_W(CNT_W)) u_wave (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick),
    .wrap     (wrap),
    .cnt      (cnt),
    .hold_val (hold_q),
    .ocr_act  (ocr_act),
    .wave     (wave),
    .match    (match)
  );

  always_comb begin
    case (mode_q)
      OM_NONINV: pol = wave;
      OM_INV:    pol = ~wave;
      default:   pol = 1'b0;
    endcase
    pwm_out = oe && pol;
  end

endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] ocr_act,
  input logic             wave,
  input logic [2:0]       sel,
  input logic             ovf_flag,
  input logic             cmp_flag,
  input logic             clr_ovf,
  input logic             clr_cmp
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // R1: counter steps by one per tick below the top value
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != TOP) |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

  // R1, R4: wrap to zero and overflow flag together
  a_r4_ovf_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == TOP) |=> (cnt == '0 && ovf_flag));

  // R2: a stopped divider freezes the counter
  a_r2_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0 || sel > 3'd5) |=> $stable(cnt));

  // R9: active compare value changes only on the wrap tick
  a_r9_ocr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && cnt == TOP) |=> $stable(ocr_act));

  // R7: match below the top value drops the waveform
  a_r7_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == ocr_act && cnt != TOP) |=> !wave);

  // R5: a match sets the compare flag
  a_r5_cmp_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == ocr_act) |=> cmp_flag);

  // R6: flags hold without a clear
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_ovf) |=> ovf_flag);
  a_r6_cmp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_flag && !clr_cmp) |=> cmp_flag);

endmodule

bind pwm_timer8 ptmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .tick     (tick),
  .cnt      (cnt),
  .ocr_act  (ocr_act),
  .wave     (wave),
  .sel      (sel_q),
  .ovf_flag (ovf_flag),
  .cmp_flag (cmp_flag),
  .clr_ovf  (clr_ovf),
  .clr_cmp  (clr_cmp)
);

// File: tb/pwm_timer8_tb.sv
module pwm_timer8_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       oe = 1'b1;
  logic       pwm_out, ovf_flag, cmp_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_timer8 u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .oe(oe), .pwm_out(pwm_out),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Scoreboard: reference state built from the requirements, one item per cycle
  typedef struct {logic in_high; logic [1:0] mode; logic ovf; logic cmp;} exp_t;
  exp_t exq[$];

  logic [1:0] m_sync = 2'b00;
  logic [2:0] m_sel = 0;
  logic [1:0] m_mode = 0;
  logic [7:0] m_cnt = 0, m_ocr = 0, m_hold = 0;
  int         m_div = 0;
  logic       m_ovf = 0, m_cmp = 0;

  always @(posedge clk) begin
    int  ratio;
    bit  tck, wrp;
    exp_t e;
    if (!rst_n) begin
      m_sync = 2'b00;
      exq.delete();
    end else begin
      if (!m_sync[1]) begin
        m_sel = 0; m_mode = 0; m_cnt = 0; m_ocr = 0; m_hold = 0;
        m_div = 0; m_ovf = 0; m_cmp = 0;
      end else begin
        case (m_sel)
          3'd1: ratio = 1;   3'd2: ratio = 8;   3'd3: ratio = 64;
          3'd4: ratio = 256; 3'd5: ratio = 1024; default: ratio = 0;
        endcase
        tck = (ratio != 0) && (m_div == ratio - 1);
        wrp = tck && (m_cnt == 8'hFF);
        if (tck && m_cnt == m_ocr) m_cmp = 1'b1;
        else if (wr_en && wr_addr == 2'd2 && wr_data[1]) m_cmp = 1'b0;
        if (wrp) m_ovf = 1'b1;
        else if (wr_en && wr_addr == 2'd2 && wr_data[0]) m_ovf = 1'b0;
        if (wr_en && wr_addr == 2'd1 && wr_data[2:0] != m_sel) m_div = 0;
        else if (ratio == 0 || tck) m_div = 0;
        else m_div = m_div + 1;
        if (wrp) m_ocr = m_hold;
        if (tck) m_cnt = m_cnt + 8'd1;
        if (wr_en && wr_addr == 2'd0) m_hold = wr_data;
        if (wr_en && wr_addr == 2'd1) begin
          m_sel = wr_data[2:0];
          m_mode = wr_data[5:4];
        end
      end
      m_sync = {m_sync[0], 1'b1};
      e.in_high = (m_cnt <= m_ocr);
      e.mode = m_mode; e.ovf = m_ovf; e.cmp = m_cmp;
      exq.push_back(e);
    end
  end

  always @(negedge clk) begin
    exp_t e;
    logic ep;
    if (rst_n && exq.size() > 0) begin
      e = exq.pop_front();
      ep = oe && ((e.mode == 2'd2) ? e.in_high : (e.mode == 2'd3) ? !e.in_high : 1'b0);
      check(pwm_out === ep, "R7/R10 pwm_out", int'(pwm_out), int'(ep));
      check(ovf_flag === e.ovf, "R4/R6 ovf_flag", int'(ovf_flag), int'(e.ovf));
      check(cmp_flag === e.cmp, "R5/R6 cmp_flag", int'(cmp_flag), int'(e.cmp));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_edge(input logic lvl);
    logic prev;
    prev = pwm_out;
    forever begin
      @(negedge clk);
      if (pwm_out == lvl && prev != lvl) break;
      prev = pwm_out;
    end
  endtask

  task automatic run_len(input logic lvl, input int start, output int n);
    n = start;
    forever begin
      @(negedge clk);
      if (pwm_out == lvl) n++;
      else break;
    end
  endtask

  task automatic period_len(output int n);
    logic prev;
    n = 0;
    prev = pwm_out;
    forever begin
      @(negedge clk);
      n++;
      if (pwm_out && !prev) break;
      prev = pwm_out;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, hi;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(pwm_out == 1'b0, "R11 reset pwm", int'(pwm_out), 0);
    check(ovf_flag == 1'b0, "R11 reset ovf", int'(ovf_flag), 0);
    check(cmp_flag == 1'b0, "R11 reset cmp", int'(cmp_flag), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pwm_out == 1'b0 && ovf_flag == 1'b0, "R11 stopped after reset", int'(ovf_flag), 0);

    // R7, R1: non-inverted, compare 100, divide by 1
    wr(2'd0, 8'd100);
    wr(2'd1, 8'h21);
    wait_edge(1'b1); wait_edge(1'b1);
    run_len(1'b1, 1, n);
    check(n == 101, "R7 high ticks for compare 100", n, 101);
    wait_edge(1'b1);
    period_len(n);
    check(n == 256, "R1 period in ticks", n, 256);

    // R7 inverted
    wr(2'd1, 8'h31);
    wait_edge(1'b0); wait_edge(1'b0);
    run_len(1'b0, 1, n);
    check(n == 101, "R7 inverted low ticks", n, 101);

    // R9 double buffering: write mid high phase
    wr(2'd1, 8'h21);
    wait_edge(1'b1);
    repeat (9) @(negedge clk);
    wr(2'd0, 8'd200);
    run_len(1'b1, 11, n);
    check(n == 101, "R9 current period keeps old duty", n, 101);
    wait_edge(1'b1);
    run_len(1'b1, 1, n);
    check(n == 201, "R9 next period uses new duty", n, 201);

    // R8 compare 0: one-tick spike
    wr(2'd0, 8'd0);
    wait_edge(1'b1); wait_edge(1'b1);
    run_len(1'b1, 1, n);
    check(n == 1, "R8 spike width at compare 0", n, 1);
    run_len(1'b0, 1, n);
    check(n == 255, "R8 low ticks at compare 0", n, 255);

    // R8 compare 255: constant level
    wr(2'd0, 8'd255);
    repeat (600) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (pwm_out) hi++; end
    check(hi == 300, "R8 constant high at compare 255", hi, 300);
    wr(2'd1, 8'h31);
    hi = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (pwm_out) hi++; end
    check(hi == 0, "R8 constant low inverted at compare 255", hi, 0);

    // R10 output enable and idle modes
    wr(2'd0, 8'd100);
    wr(2'd1, 8'h21);
    oe = 1'b0;
    hi = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (pwm_out) hi++; end
    check(hi == 0, "R10 oe low forces output low", hi, 0);
    oe = 1'b1;
    wr(2'd1, 8'h11);
    hi = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (pwm_out) hi++; end
    check(hi == 0, "R10 mode 1 output low", hi, 0);

    // R6: clears every cycle while flags keep being set
    wr(2'd1, 8'h21);
    for (int i = 0; i < 600; i++) wr(2'd2, 8'h03);
    wr(2'd2, 8'h03);
    check(1'b1, "R6 set-over-clear covered by scoreboard", 0, 0);

    // R2, R3: divide by 8 and by 64
    wr(2'd1, 8'h22);
    wait_edge(1'b1); wait_edge(1'b1);
    run_len(1'b1, 1, n);
    check(n == 808, "R2 high clocks at divide 8", n, 808);
    wait_edge(1'b1);
    period_len(n);
    check(n == 2048, "R2 period clocks at divide 8", n, 2048);
    wr(2'd1, 8'h23);
    wait_edge(1'b1);
    period_len(n);
    check(n == 16384, "R2 R3 period clocks at divide 64", n, 16384);

    // R3: repeated select changes restart the divider
    for (int i = 0; i < 40; i++) begin
      wr(2'd1, 8'h22);
      repeat (5) @(negedge clk);
      wr(2'd1, 8'h23);
      repeat (5) @(negedge clk);
    end

    // R2: stop holds counter, output and flags
    wr(2'd1, 8'h20);
    wr(2'd2, 8'h03);
    hi = pwm_out;
    n = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (pwm_out != hi || ovf_flag || cmp_flag) n++;
    end
    check(n == 0, "R2 stopped timer holds", n, 0);

    // R5: running again sets the compare flag
    wr(2'd1, 8'h21);
    repeat (300) @(negedge clk);
    check(cmp_flag == 1'b1, "R5 compare flag set", int'(cmp_flag), 1);
    check(ovf_flag == 1'b1, "R4 overflow flag set", int'(ovf_flag), 1);

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule